// File: doc/BRIEF.md
# I2C DAC Address-Bit Reader

This block is a bit-level I2C master that finds out which three programmable address bits a DAC-type device currently holds. Other devices share the same bus. The device gives up those bits only if a device-specific strobe line (LDAC) moves partway through a command byte, before that byte's acknowledge clock. An ordinary byte-oriented I2C controller cannot place an edge there, so this block generates every SCL and SDA edge itself, on open-drain pins.

Software starts an operation by writing a guarded control word. The upper half of the word must equal a fixed key. The low field selects one of several quads, and the strobe line of the selected quad is the one that toggles. After the write is accepted, the block asks the selected quad to enter its self-test mode. It waits for that request to be acknowledged. It then runs this bus sequence:

- START
- the general-call byte
- the read-address command byte, with the strobe timed inside that byte
- a repeated START
- a read addressed to an address where nothing normally answers, followed by one data byte

A missing acknowledge means the strobe timing did not take. The returned byte is checked for its fixed marker bits. The top three bits are then reported as the current address bits.

Top module: `dac_addr_reader`

## Requirements
- R1: After reset, `busy`, `bist_req`, `done`, `ack_error` and `format_error` are 0, `addr_bits` is 0, `scl_oe` and `sda_oe` are 0 (both lines released) and every bit of `ldac_n` is 1.
- R2: A write on `ctrl_wr` is accepted only when `ctrl_wdata[31:16]` equals the key 0xD7AC and no operation is in progress. The quad number is taken from `ctrl_wdata[1:0]`. Bits [4:2] carry the requested new address bits, which do not change the read sequence. A write that is not accepted has no effect: `busy` stays as it was and the quad of a running operation is kept.
- R3: On acceptance, `busy` and `bist_req` rise. Both lines stay released until `bist_ack` is seen high.
- R4: The bus sequence is, in order:
  - START;
  - byte 0x00;
  - byte 0x0C;
  - a repeated START, with no STOP before it;
  - byte 0xCF;
  - one byte read in, answered by the master with NACK;
  - STOP.

  Bytes go out MSB first. SCL is pulled low through `scl_oe=1` and SDA through `sda_oe=1`.
- R5: During byte 0x0C, the selected quad's `ldac_n` goes low while SCL is low, after the 7th data clock. It is low at the 8th data clock and at the acknowledge clock. It returns high together with the SCL fall that ends the acknowledge clock. Every other quad's `ldac_n` stays high, and at most one bit of `ldac_n` is ever low.
- R6: If any of the bytes 0x00, 0x0C or 0xCF is not acknowledged (SDA high at its 9th clock), the block raises `ack_error`, skips the rest of the sequence, issues STOP, and leaves `addr_bits` unchanged.
- R7: The read byte is valid when its bit 0 is 0 and its bit 4 is 1. In that case `addr_bits` takes bits [7:5] of the byte. Otherwise `format_error` is set and `addr_bits` is unchanged.
- R8: At the end of an operation, `done` is high for exactly one cycle. `busy` and `bist_req` fall in that same cycle. `ack_error` and `format_error` hold their values until the next accepted start.
- R9: Within a byte, the SCL period is 4 × (`div_cfg` + 1) clock cycles. `div_cfg` is captured when the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word: key [31:16], new bits [4:2], quad [1:0] |
| div_cfg | input | DIV_W | Quarter-bit divider; one quarter lasts div_cfg+1 cycles |
| bist_ack | input | 1 | Selected quad has entered self-test mode |
| sda_in | input | 1 | Level on the SDA line |
| bist_req | output | 1 | Request that the selected quad enter self-test mode |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| ldac_n | output | NQUAD | Active-low strobe, one per quad |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| ack_error | output | 1 | A byte was not acknowledged |
| format_error | output | 1 | Read byte failed the marker-bit check |
| addr_bits | output | 3 | Last valid address bits read |

## Verification
The bench contains a bus responder. It acknowledges the 0xCF read address only if the selected strobe was high at the 7th data clock of the command byte, and low at the 8th data clock and at the acknowledge clock. As a result, a strobe placed one bit early or late, released before the acknowledge clock, or sent to the wrong quad turns into an `ack_error` rather than passing unnoticed.

The bench walks every possible read byte across all quads. A design that checks the wrong marker bit, or takes the wrong three bits, reports the wrong `addr_bits` or a wrong `format_error`. A refused acknowledge on each of the three written bytes exposes designs that keep going, that overwrite `addr_bits`, or that omit the STOP.

Two further stimuli target the acceptance logic: writes with a wrong key, and a second write made while an operation is in progress. A design that accepts either one starts a run or switches the strobe to a different quad. Finally, measuring the SCL period at several divider values catches an off-by-one error in the quarter counter.

// File: rtl/dar_pkg.sv
package dar_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_BIST,
    S_START,
    S_WR_GC,
    S_WR_CMD,
    S_RSTART,
    S_WR_RD,
    S_RD,
    S_STOP,
    S_FIN
  } seq_t;

  localparam logic [7:0] BYTE_GCALL  = 8'h00;
  localparam logic [7:0] BYTE_GETADR = 8'h0C;
  localparam logic [7:0] BYTE_RDADR  = 8'hCF;

endpackage

// File: rtl/dar_quarter_tick.sv
module dar_quarter_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)     cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == div);

  // R9
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0) |=> !tick);

endmodule

// File: rtl/dar_key_gate.sv
module dar_key_gate #(
  parameter int          QUAD_W = 2,
  parameter logic [15:0] KEY    = 16'hD7AC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [31:0]       wdata,
  input  logic              busy,
  output logic              accept,
  output logic [QUAD_W-1:0] quad
);
  logic ok;
  assign ok = wr && !busy && !accept && (wdata[31:16] == KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      accept <= 1'b0;
      quad   <= '0;
    end else begin
      accept <= ok;
      if (ok) quad <= wdata[QUAD_W-1:0];
    end
  end

  // R2
  accept_src_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> $past(wr) && !$past(busy));

endmodule

// File: rtl/dar_ldac_drive.sv
module dar_ldac_drive #(
  parameter int NQUAD  = 4,
  parameter int QUAD_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [QUAD_W-1:0] quad,
  output logic [NQUAD-1:0]  ldac_n
);
  logic [NQUAD-1:0] sel;

  for (genvar gi = 0; gi < NQUAD; gi++) begin : g_sel
    assign sel[gi] = strobe && (quad == QUAD_W'(gi));
  end

  always_ff @(posedge clk) begin
    if (rst) ldac_n <= '1;
    else     ldac_n <= ~sel;
  end

  // R5
  ldac_single_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~ldac_n) <= 1);

endmodule

// File: rtl/dac_addr_reader.sv
module dac_addr_reader
  import dar_pkg::*;
#(
  parameter int          DIV_W = 8,
  parameter int          NQUAD = 4,
  parameter logic [15:0] KEY   = 16'hD7AC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic [31:0]      ctrl_wdata,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic             bist_ack,
  input  logic             sda_in,
  output logic             bist_req,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic [NQUAD-1:0] ldac_n,
  output logic             busy,
  output logic             done,
  output logic             ack_error,
  output logic             format_error,
  output logic [2:0]       addr_bits
);
  localparam int QUAD_W = (NQUAD > 1) ? $clog2(NQUAD) : 1;

  seq_t              state;
  logic [1:0]        q;
  logic [3:0]        bit_idx;
  logic [7:0]        rd_sh;
  logic [DIV_W-1:0]  div_r;
  logic              nack_r;
  logic              accept;
  logic [QUAD_W-1:0] quad;
  logic              tick;
  logic              run;
  logic              ldac_on;
  logic              scl_pull_d, sda_pull_d;
  logic [7:0]        cur_byte;

  dar_key_gate #(.QUAD_W(QUAD_W), .KEY(KEY)) u_gate (
    .clk(clk), .rst(rst), .wr(ctrl_wr), .wdata(ctrl_wdata),
    .busy(busy), .accept(accept), .quad(quad)
  );

  assign run = (state != S_IDLE) && (state != S_BIST) && (state != S_FIN);

  dar_quarter_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(run), .div(div_r), .tick(tick)
  );

  assign ldac_on = (state == S_WR_CMD) &&
                   ((bit_idx == 4'd8) || (bit_idx == 4'd7 && q != 2'd0));

  dar_ldac_drive #(.NQUAD(NQUAD), .QUAD_W(QUAD_W)) u_ldac (
    .clk(clk), .rst(rst), .strobe(ldac_on), .quad(quad), .ldac_n(ldac_n)
  );

  always_comb begin
    unique case (state)
      S_WR_GC:  cur_byte = BYTE_GCALL;
      S_WR_CMD: cur_byte = BYTE_GETADR;
      default:  cur_byte = BYTE_RDADR;
    endcase
  end

  // Line drive per quarter: SCL low in q0/q1, high in q2/q3; SDA held in q0.
  always_comb begin
    scl_pull_d = 1'b0;
    sda_pull_d = 1'b0;
    unique case (state)
      S_START: sda_pull_d = q[1];
      S_WR_GC, S_WR_CMD, S_WR_RD: begin
        scl_pull_d = ~q[1];
        if (q == 2'd0)             sda_pull_d = sda_oe;
        else if (bit_idx != 4'd8)  sda_pull_d = ~cur_byte[~bit_idx[2:0]];
      end
      S_RD: begin
        scl_pull_d = ~q[1];
        sda_pull_d = (q == 2'd0) ? sda_oe : 1'b0;
      end
      S_RSTART: begin
        scl_pull_d = ~q[1];
        sda_pull_d = (q == 2'd0) ? sda_oe : (q == 2'd3);
      end
      S_STOP: begin
        scl_pull_d = ~q[1];
        sda_pull_d = (q == 2'd0) ? sda_oe : (q != 2'd3);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      q            <= 2'd0;
      bit_idx      <= 4'd0;
      rd_sh        <= 8'd0;
      div_r        <= '0;
      nack_r       <= 1'b0;
      busy         <= 1'b0;
      done         <= 1'b0;
      ack_error    <= 1'b0;
      format_error <= 1'b0;
      addr_bits    <= 3'd0;
      scl_oe       <= 1'b0;
      sda_oe       <= 1'b0;
    end else begin
      scl_oe <= scl_pull_d;
      sda_oe <= sda_pull_d;
      done   <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          busy         <= 1'b1;
          ack_error    <= 1'b0;
          format_error <= 1'b0;
          nack_r       <= 1'b0;
          div_r        <= div_cfg;
          state        <= S_BIST;
        end
        S_BIST: if (bist_ack) begin
          q       <= 2'd0;
          bit_idx <= 4'd0;
          state   <= S_START;
        end
        S_FIN: begin
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= S_IDLE;
          if (nack_r)                        ack_error    <= 1'b1;
          else if (!rd_sh[0] && rd_sh[4])    addr_bits    <= rd_sh[7:5];
          else                               format_error <= 1'b1;
        end
        default: if (tick) begin
          q <= q + 2'd1;
          if (q == 2'd3) begin
            unique case (state)
              S_START: begin
                bit_idx <= 4'd0;
                state   <= S_WR_GC;
              end
              S_WR_GC, S_WR_CMD, S_WR_RD: begin
                if (bit_idx != 4'd8) bit_idx <= bit_idx + 4'd1;
                else begin
                  bit_idx <= 4'd0;
                  if (sda_in) begin
                    nack_r <= 1'b1;
                    state  <= S_STOP;
                  end else if (state == S_WR_GC)  state <= S_WR_CMD;
                  else if (state == S_WR_CMD)     state <= S_RSTART;
                  else                            state <= S_RD;
                end
              end
              S_RD: begin
                if (bit_idx != 4'd8) begin
                  rd_sh   <= {rd_sh[6:0], sda_in};
                  bit_idx <= bit_idx + 4'd1;
                end else begin
                  bit_idx <= 4'd0;
                  state   <= S_STOP;
                end
              end
              S_RSTART: state <= S_WR_RD;
              default:  state <= S_FIN;
            endcase
          end
        end
      endcase
    end
  end

  assign bist_req = busy;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_oe && !sda_oe));

  // R6
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ack_error && format_error));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && (ack_error || format_error)) |-> $stable(addr_bits));

  // R5
  ldac_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (ldac_n != $past(ldac_n)) |-> scl_oe);

  // R3
  bist_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_START) |-> busy);

endmodule

// File: tb/dac_addr_reader_bench.sv
module dac_addr_reader_bench;
  localparam int          NQ  = 4;
  localparam logic [15:0] KEY = 16'hD7AC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        ctrl_wr = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [7:0]  div_cfg = '0;
  logic        bist_ack = 1'b0;
  logic        bist_req, scl_oe, sda_oe, busy, done, ack_error, format_error;
  logic [NQ-1:0] ldac_n;
  logic [2:0]  addr_bits;
  logic        slv_pull = 1'b0;

  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | slv_pull);
  wire sda_in   = sda_line;

  dac_addr_reader u_dac_addr_reader (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .div_cfg(div_cfg), .bist_ack(bist_ack), .sda_in(sda_in),
    .bist_req(bist_req), .scl_oe(scl_oe), .sda_oe(sda_oe), .ldac_n(ldac_n),
    .busy(busy), .done(done), .ack_error(ack_error),
    .format_error(format_error), .addr_bits(addr_bits)
  );

  int total = 0;
  int fails = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // Bus responder
  int rcnt = 0, bidx = 0, n_start = 0, n_rstart = 0, n_stop = 0, nrise = 0;
  int t_r1 = 0, t_r2 = 0, tq = 0;
  bit in_txn = 0, cf_acked = 0, l6 = 0, l7 = 1, lack = 1, others_ok = 1;
  bit cfg_gc = 1, cfg_cmd = 1, cfg_dev = 1;
  logic [7:0] cfg_rd = '0, sh = '0, rx0 = '0, rx1 = '0, rx2 = '0;

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    if (in_txn) n_rstart++;
    in_txn = 1;
    n_start++;
    rcnt = 0;
  end

  always @(posedge sda_line) if (scl_line === 1'b1 && in_txn) begin
    in_txn = 0;
    n_stop++;
  end

  always @(posedge scl_line) if (in_txn) begin
    rcnt++;
    if (rcnt <= 8) sh = {sh[6:0], sda_line};
    if (bidx == 0) begin
      nrise++;
      if (nrise == 1) t_r1 = cyc;
      if (nrise == 2) t_r2 = cyc;
    end
    if (bidx == 1) begin
      if ((ldac_n | (NQ'(1) << tq)) != '1) others_ok = 0;
      if (rcnt == 7) l6 = ldac_n[tq];
      if (rcnt == 8) l7 = ldac_n[tq];
      if (rcnt == 9) lack = ldac_n[tq];
    end
  end

  always @(negedge scl_line) if (in_txn) begin
    if (rcnt == 8) begin
      case (bidx)
        0: begin rx0 = sh; slv_pull = cfg_gc; end
        1: begin rx1 = sh; slv_pull = cfg_cmd; end
        2: begin
          rx2 = sh;
          cf_acked = cfg_dev && l6 && !l7 && !lack && others_ok && (sh == 8'hCF);
          slv_pull = cf_acked;
        end
        default: slv_pull = 1'b0;
      endcase
    end else if (rcnt == 9) begin
      rcnt = 0;
      bidx++;
      slv_pull = (bidx == 3 && cf_acked) ? ~cfg_rd[7] : 1'b0;
    end else if (bidx == 3 && cf_acked && rcnt >= 1 && rcnt <= 7) begin
      slv_pull = ~cfg_rd[7 - rcnt];
    end
  end

  logic [2:0] exp_addr = 3'd0;

  task automatic write_ctrl(input logic [15:0] key, input int quad, input int nb);
    @(negedge clk);
    ctrl_wr    = 1'b1;
    ctrl_wdata = {key, 11'd0, 3'(nb), 2'(quad)};
    @(negedge clk);
    ctrl_wr    = 1'b0;
  endtask

  task automatic run_op(input int quad, input int nb, input logic [7:0] rd,
                        input bit a_gc, input bit a_cmd, input bit a_dev,
                        input int dv, input int bdelay, input bit midwrite);
    bit wait_ok;
    bit exp_ack;
    bit valid;
    int w;
    rcnt = 0; bidx = 0; n_start = 0; n_rstart = 0; n_stop = 0; nrise = 0;
    in_txn = 0; cf_acked = 0; l6 = 0; l7 = 1; lack = 1; others_ok = 1;
    slv_pull = 1'b0; rx0 = 8'h55; rx1 = 8'h55; rx2 = 8'h55;
    cfg_gc = a_gc; cfg_cmd = a_cmd; cfg_dev = a_dev; cfg_rd = rd; tq = quad;
    div_cfg = 8'(dv);
    write_ctrl(KEY, quad, nb);
    wait_ok = 1;
    for (int i = 0; i < bdelay; i++) begin
      @(negedge clk);
      if (!(busy && bist_req && !scl_oe && !sda_oe && ldac_n == '1)) wait_ok = 0;
    end
    // R3: held off until the self-test acknowledge
    chk(wait_ok, "R3 bist wait", busy, 1);
    bist_ack = 1'b1;
    if (midwrite) begin
      repeat (20) @(negedge clk);
      write_ctrl(KEY, (quad + 1) % NQ, nb);
    end
    w = 0;
    while (!done && w < 20000) begin
      @(negedge clk);
      w++;
    end
    // R8
    chk(done && !busy && !bist_req, "R8 done/busy", {done, busy, bist_req}, 3'b100);
    exp_ack = !(a_gc && a_cmd && a_dev);
    valid   = !exp_ack && !rd[0] && rd[4];
    if (valid) exp_addr = rd[7:5];
    // R6
    chk(ack_error == exp_ack, "R6 ack_error", ack_error, exp_ack);
    // R7
    chk(format_error == (!exp_ack && !valid), "R7 format_error", format_error,
        !exp_ack && !valid);
    chk(addr_bits == exp_addr, "R7 addr_bits", addr_bits, exp_addr);
    // R4
    chk(rx0 == 8'h00, "R4 byte0", rx0, 8'h00);
    chk(n_stop == 1, "R4 stop count", n_stop, 1);
    if (a_gc) chk(rx1 == 8'h0C, "R4 byte1", rx1, 8'h0C);
    if (a_gc && a_cmd) begin
      chk(rx2 == 8'hCF && n_rstart == 1, "R4 rstart+byte2", rx2, 8'hCF);
      // R5
      chk(l6 && !l7 && !lack, "R5 ldac timing", {l6, l7, lack}, 3'b100);
    end else begin
      chk(n_rstart == 0, "R4 no rstart", n_rstart, 0);
    end
    // R5
    chk(others_ok && ldac_n == '1, "R5 other quads", ldac_n, 4'hF);
    // R9
    chk((t_r2 - t_r1) == 4 * (dv + 1), "R9 scl period", t_r2 - t_r1, 4 * (dv + 1));
    @(negedge clk);
    // R8
    chk(!done, "R8 done single", done, 0);
    bist_ack = 1'b0;
    if (midwrite) begin
      repeat (10) @(negedge clk);
      // R2: write during the run ignored
      chk(!busy, "R2 busy write ignored", busy, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!busy && !bist_req && !done && !ack_error && !format_error, "R1 flags",
        {busy, bist_req, done, ack_error, format_error}, 0);
    chk(!scl_oe && !sda_oe && ldac_n == '1 && addr_bits == 3'd0, "R1 bus",
        {scl_oe, sda_oe, ldac_n}, 6'h0F);

    // R2: wrong keys
    write_ctrl(KEY ^ 16'h0001, 0, 0);
    repeat (10) @(negedge clk);
    chk(!busy && !bist_req && !scl_oe, "R2 bad key", busy, 0);
    write_ctrl(16'h0000, 2, 5);
    repeat (10) @(negedge clk);
    chk(!busy && !bist_req && !scl_oe, "R2 zero key", busy, 0);

    // R7: every read byte, quads rotating, new-bits field varied
    for (int v = 0; v < 256; v++)
      run_op(v % NQ, (v / 4) % 8, 8'(v), 1, 1, 1, 0, 2, 0);

    // R9: other dividers on each quad
    for (int qd = 0; qd < NQ; qd++)
      run_op(qd, qd, 8'h90 | 8'(qd << 5), 1, 1, 1, 1 + 2 * qd, 3, 0);

    // R6: refused acknowledge on each byte
    run_op(1, 0, 8'hF0, 0, 1, 1, 1, 2, 0);
    run_op(2, 0, 8'hF0, 1, 0, 1, 1, 2, 0);
    run_op(3, 0, 8'hF0, 1, 1, 0, 1, 2, 0);

    // R3: long self-test wait; R2: valid write while busy
    run_op(0, 7, 8'h50, 1, 1, 1, 2, 40, 0);
    run_op(2, 3, 8'hB0, 1, 1, 1, 2, 2, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule